// File: doc/BRIEF.md
# Zero-Byte Comma Substitution Encoder

This block sits in front of a byte-oriented line encoder and serializer. Each clock it takes one parallel word of sampled input bits. It splits the word into byte lanes. A lane whose byte is all zeros is swapped for a comma control character, and that lane's control flag is raised. A lane holding any non-zero value passes through with its flag low. The comma depends on the lane: the most significant lane uses K28.5 (0xBC) and every other lane uses K28.1 (0x3C). Zero bytes are common when the input lines are idle. The receiver therefore sees commas often, gets byte alignment from them, and can tell from the comma type which byte is the upper one.

The input is captured in a register. The substituted word and its flags come out of a second register, so the result appears exactly one cycle after the word is presented. Byte count and comma values are parameters. The defaults give a 16-bit word with a 2-bit flag.

Top module: `zcomma_enc`

## Requirements
- R1: While `rst` is high at a rising clock edge, `data_o` and `ctl_o` are driven to all zeros at that edge and stay zero while reset is held.
- R2: If the upper byte `word_i[15:8]` is 0x00, `data_o[15:8]` is 0xBC and `ctl_o[1]` is 1.
- R3: If the lower byte `word_i[7:0]` is 0x00, `data_o[7:0]` is 0x3C and `ctl_o[0]` is 1.
- R4: A non-zero byte is copied to the same position of `data_o` without change, and its flag (`ctl_o[1]` for the upper byte, `ctl_o[0]` for the lower) is 0.
- R5: Each lane is handled on its own. An all-zero word gives `data_o` = 0xBC3C and `ctl_o` = 2'b11, and a zero in one lane does not change the other lane.
- R6: The output for a word sampled at rising edge N is visible after rising edge N+1, and one new word is accepted on every cycle.
- R7: When `ctl_o[i]` is 1, lane i of `data_o` holds the comma for that lane: 0xBC for lane 1 and 0x3C for lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 16 | Sampled input bits, lane 1 = [15:8] |
| data_o | output | 16 | Data bytes after substitution |
| ctl_o | output | 2 | Control-character flag per lane |

## Verification
The in-RTL assertions check on every cycle that:
- each raised flag comes with its lane's comma value;
- each lane's result matches the input word registered one cycle earlier;
- reset clears the outputs.

Only the bench's scenarios can show the following:
- exact values at the boundaries, such as 0x01 and 0x80 passing through while 0x00 is swapped;
- that 0xBC and 0x3C arriving as data keep their flag low;
- that a word streamed on back-to-back cycles lands one cycle later with nothing dropped.

// File: rtl/zcomma_pkg.sv
package zcomma_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] COMMA_HI = 8'hBC; // K28.5
  localparam logic [BYTE_W-1:0] COMMA_LO = 8'h3C; // K28.1

  typedef struct packed {
    logic [BYTE_W-1:0] val;
    logic              ctl;
  } lane_t;
endpackage

// File: rtl/zcomma_lane.sv
module zcomma_lane
  import zcomma_pkg::*;
#(
  parameter logic [BYTE_W-1:0] COMMA = COMMA_LO
) (
  input  logic [BYTE_W-1:0] byte_i,
  output lane_t             lane_o
);
  logic is_zero;
  assign is_zero = (byte_i == '0);

  always_comb begin
    lane_o.ctl = is_zero;
    lane_o.val = is_zero ? COMMA : byte_i;
  end
endmodule

// File: rtl/zcomma_enc.sv
module zcomma_enc
  import zcomma_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*BYTE_W-1:0]   word_i,
  output logic [LANES*BYTE_W-1:0]   data_o,
  output logic [LANES-1:0]          ctl_o
);
  localparam int unsigned WORD_W = LANES * BYTE_W;

  logic [WORD_W-1:0] in_q;
  lane_t             lane_c [LANES];
  logic              vld_q;

  // Input capture register
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      in_q  <= word_i;
      vld_q <= 1'b1;
    end
  end

  // One substitution cell per lane; the top lane uses the high comma
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [BYTE_W-1:0] CSEL = (g == LANES-1) ? COMMA_HI : COMMA_LO;
    zcomma_lane #(.COMMA(CSEL)) u_lane (
      .byte_i (in_q[g*BYTE_W +: BYTE_W]),
      .lane_o (lane_c[g])
    );

    // Output register for this lane
    always_ff @(posedge clk) begin
      if (rst) begin
        data_o[g*BYTE_W +: BYTE_W] <= '0;
        ctl_o[g]                   <= 1'b0;
      end else begin
        data_o[g*BYTE_W +: BYTE_W] <= lane_c[g].val;
        ctl_o[g]                   <= lane_c[g].ctl;
      end
    end

    AST_FLAG_COMMA: assert property (@(posedge clk) disable iff (rst)
      ctl_o[g] |-> (data_o[g*BYTE_W +: BYTE_W] == CSEL)); // R7

    AST_LANE_PASS: assert property (@(posedge clk) disable iff (rst)
      (vld_q && $past(word_i[g*BYTE_W +: BYTE_W]) != '0) |=>
        (!ctl_o[g] && data_o[g*BYTE_W +: BYTE_W] == $past(word_i[g*BYTE_W +: BYTE_W], 2))); // R4

    AST_LANE_SUB: assert property (@(posedge clk) disable iff (rst)
      (vld_q && $past(word_i[g*BYTE_W +: BYTE_W]) == '0) |=> ctl_o[g]); // R5
  end

  AST_RESET_CLR: assert property (@(posedge clk)
    $past(rst) |-> (data_o == '0 && ctl_o == '0)); // R1

  AST_HI_COMMA: assert property (@(posedge clk) disable iff (rst)
    (vld_q && $past(word_i[WORD_W-1 -: BYTE_W]) == '0) |=>
      (data_o[WORD_W-1 -: BYTE_W] == COMMA_HI)); // R2

  AST_LO_COMMA: assert property (@(posedge clk) disable iff (rst)
    (vld_q && $past(word_i[BYTE_W-1:0]) == '0) |=>
      (data_o[BYTE_W-1:0] == COMMA_LO)); // R3
endmodule

// File: tb/tb_zcomma_enc.sv
module tb_zcomma_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] word_i = '0;
  logic [15:0] data_o;
  logic [1:0]  ctl_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  zcomma_enc dut (.clk(clk), .rst(rst), .word_i(word_i), .data_o(data_o), .ctl_o(ctl_o));

  function automatic logic [17:0] model(input logic [15:0] w);
    logic [7:0] h, l;
    logic       kh, kl;
    kh = (w[15:8] == 8'h00); h = kh ? 8'hBC : w[15:8];
    kl = (w[7:0]  == 8'h00); l = kl ? 8'h3C : w[7:0];
    return {kh, kl, h, l};
  endfunction

  task automatic check(input string req, input logic [17:0] exp);
    n_chk++;
    if ({ctl_o, data_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: got ctl=%b data=%h, expected ctl=%b data=%h",
               req, ctl_o, data_o, exp[17:16], exp[15:0]);
    end
  endtask

  // Present word, then after the input and output registers sample mid-cycle
  task automatic apply(input string req, input logic [15:0] w);
    @(negedge clk); word_i = w;
    @(negedge clk); @(negedge clk);
    check(req, model(w));
  endtask

  task automatic t_reset;  // R1
    rst = 1'b1; word_i = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1", 18'h0);
    word_i = 16'h1234; @(negedge clk);
    check("R1", 18'h0);
    rst = 1'b0;
  endtask

  task automatic t_hi_zero;  // R2
    apply("R2", 16'h00A5);
    apply("R2", 16'h0001);
  endtask

  task automatic t_lo_zero;  // R3
    apply("R3", 16'h5A00);
    apply("R3", 16'h8000);
  endtask

  task automatic t_pass;  // R4
    apply("R4", 16'h0101);
    apply("R4", 16'h8080);
    apply("R4", 16'hBC3C);
    apply("R4", 16'hFFFF);
  endtask

  task automatic t_both;  // R5 R7
    apply("R5", 16'h0000);
    check("R7", {2'b11, 16'hBC3C});
  endtask

  task automatic t_stream;  // R6
    logic [15:0] seq [6] = '{16'h0000, 16'h1200, 16'h0034, 16'h5678, 16'h0000, 16'h9A00};
    @(negedge clk); word_i = seq[0];
    @(negedge clk); word_i = seq[1];
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      word_i = (i + 2 < 6) ? seq[i+2] : 16'h7777;
      check("R6", model(seq[i]));
    end
  endtask

  initial begin
    t_reset();
    t_hi_zero();
    t_lo_zero();
    t_pass();
    t_both();
    t_stream();
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule